// File: doc/BRIEF.md
# Two-Row Precalculation Bit-Serial Adder Sequencer

This controller adds two N-bit two's-complement words inside a pair of stateful resistive cell rows. It never computes the sum in logic. Instead it issues wordline levels and per-cell bitline commands, and each cell updates its own stored bit. A cell holds its value when its bitline is left at ground (undriven). When the bitline is driven, the cell's next state is `wl | ~bl` if it stores 1, and `wl & ~bl` if it stores 0. Reading a cell means driving the wordline high and its bitline low. The read returns the old content and leaves the cell at 1.

There are two rows, each of N+1 cells. The calculation row ends up holding the result. The auxiliary row holds carries computed ahead of time.

The sequence has four phases:
- **Clear:** one step sets every cell to 1.
- **Carry-in:** one step writes the carry-in into every cell.
- **Preparation:** N+1 steps. Each step forms one partial sum and advances the carries in both rows in parallel.
- **Finishing:** N+1 steps. Each step reads one auxiliary carry and uses that sensed bit, in the same cycle, as the bitline of one calculation cell to finish its sum bit.

The operands are sign-extended by one bit, so the result has N+1 bits and cannot overflow. A subtract input inverts b and forces the carry-in to 1. The whole run takes 2(N+1)+2 cycles. A one-cycle done pulse follows it.

Top module: `precalcAdderSeq`

## Requirements
- R1: After reset and whenever idle, busy and done are low, both wordlines are low, and no bitline of either row is driven.
- R2: A start seen while idle latches a, b, c0 and sub. busy is then high for exactly 2(N+1)+2 cycles. done is high for exactly the single cycle after busy falls.
- R3: The first busy cycle is the clear step: both wordlines are 1, every bitline of both rows is driven, and every bitline level is 0.
- R4: The second busy cycle is the carry-in step: both wordlines carry the effective carry-in, and every bitline of both rows is driven at level 1.
- R5: Preparation step i (i = 0..N, busy cycles 3..N+3) works as follows. Both wordlines carry a_i. In the calculation row, cell i is driven with b_i, cells above i are driven with ~b_i, and cells below i are undriven. In the auxiliary row, cells i and above are driven with ~b_i, and cells below i are undriven.
- R6: Finishing step i (i = 0..N, busy cycles N+4..2N+4) works as follows. The auxiliary wordline is 1, and only auxiliary cell i is driven, at level 0. The calculation wordline is b_i. Only calculation cell i is driven, at the level present on auxSense in that same cycle.
- R7: Bit N of each operand is a copy of bit N-1. Once done is seen, the calculation row holds the (N+1)-bit two's-complement value a + b + c0.
- R8: With sub = 1, b is inverted and the carry-in is forced to 1, so the calculation row ends with a - b, whatever c0 is.
- R9: A start pulse while busy is ignored. The command sequence, its length and the final result all follow the operands latched at the accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an operation (honoured only while idle) |
| sub | input | 1 | 1 = subtract b from a |
| aIn | input | N | Operand a, two's complement |
| bIn | input | N | Operand b, two's complement |
| cIn | input | 1 | Carry-in for addition |
| auxSense | input | 1 | Sensed old content of the auxiliary cell being read |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle pulse: result present in calculation row |
| calcWl | output | 1 | Calculation row wordline level |
| calcBlDrv | output | N+1 | Per-cell bitline drive enable, calculation row (0 = ground) |
| calcBlVal | output | N+1 | Per-cell bitline level, calculation row |
| auxWl | output | 1 | Auxiliary row wordline level |
| auxBlDrv | output | N+1 | Per-cell bitline drive enable, auxiliary row |
| auxBlVal | output | N+1 | Per-cell bitline level, auxiliary row |

## Verification
The hardest condition to produce from the ports is a finishing step in which the sensed carry really comes from a cell state built up by every earlier command. A wrong mask, level or ordering anywhere upstream shows up only as a wrong bit several cycles later. The bench therefore keeps a behavioural model of both cell rows that obeys the per-cell update rule, and feeds auxSense from the model's stored carries. Stimulus covers every operand pair at N = 4 in add mode with both carry-in values and in subtract mode, so every carry chain and every sign-duplication case reaches the finishing phase. The per-cycle expected commands, including the carry bit expected on each finishing bitline, are derived from plain arithmetic.

// File: rtl/adderSeqPkg.sv
package adderSeqPkg;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_INIT,
    PH_PROG,
    PH_PREP,
    PH_FIN
  } phase_t;

  typedef struct packed {
    phase_t phase;
    logic   load;
  } ctrlStb_t;

endpackage

// File: rtl/addSeqCtrl.sv
module addSeqCtrl
  import adderSeqPkg::*;
#(
  parameter int N    = 8,
  parameter int IDXW = $clog2(N + 1)
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            start,
  output ctrlStb_t        stb,
  output logic [IDXW-1:0] stepIdx,
  output logic            busy,
  output logic            done
);

  localparam logic [IDXW-1:0] LAST_STEP = IDXW'(N);

  phase_t          phase;
  logic [IDXW-1:0] idx;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phase <= PH_IDLE;
      idx   <= '0;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (phase)
        PH_IDLE: if (start) phase <= PH_INIT;
        PH_INIT: phase <= PH_PROG;
        PH_PROG: begin
          phase <= PH_PREP;
          idx   <= '0;
        end
        PH_PREP: begin
          if (idx == LAST_STEP) begin
            phase <= PH_FIN;
            idx   <= '0;
          end else begin
            idx <= idx + 1'b1;
          end
        end
        PH_FIN: begin
          if (idx == LAST_STEP) begin
            phase <= PH_IDLE;
            idx   <= '0;
            done  <= 1'b1;
          end else begin
            idx <= idx + 1'b1;
          end
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end

  always_comb begin
    stb.phase = phase;
    stb.load  = (phase == PH_IDLE) && start;
  end

  assign stepIdx = idx;
  assign busy    = (phase != PH_IDLE);

endmodule

// File: rtl/addSeqData.sv
module addSeqData
  import adderSeqPkg::*;
#(
  parameter int N    = 8,
  parameter int W    = N + 1,
  parameter int IDXW = $clog2(N + 1)
) (
  input  logic            clk,
  input  logic            rstN,
  input  ctrlStb_t        stb,
  input  logic [IDXW-1:0] stepIdx,
  input  logic            sub,
  input  logic [N-1:0]    aIn,
  input  logic [N-1:0]    bIn,
  input  logic            cIn,
  input  logic            auxSense,
  output logic            calcWl,
  output logic [W-1:0]    calcBlDrv,
  output logic [W-1:0]    calcBlVal,
  output logic            auxWl,
  output logic [W-1:0]    auxBlDrv,
  output logic [W-1:0]    auxBlVal
);

  logic [W-1:0] aOp;
  logic [W-1:0] bOp;
  logic         carryIn;
  logic [N-1:0] bEff;

  assign bEff = sub ? ~bIn : bIn;

  // Operands are captured with the sign bit duplicated into position N
  always_ff @(posedge clk) begin
    if (!rstN) begin
      aOp     <= '0;
      bOp     <= '0;
      carryIn <= 1'b0;
    end else if (stb.load) begin
      aOp     <= {aIn[N-1], aIn};
      bOp     <= {bEff[N-1], bEff};
      carryIn <= sub | cIn;
    end
  end

  // Per-cell position masks relative to the current step
  logic [W-1:0] selHere;
  logic [W-1:0] selAbove;

  for (genvar j = 0; j < W; j++) begin : g_cellSel
    assign selHere[j]  = (stepIdx == IDXW'(j));
    assign selAbove[j] = (IDXW'(j) > stepIdx);
  end

  logic aBit;
  logic bBit;

  assign aBit = aOp[stepIdx];
  assign bBit = bOp[stepIdx];

  always_comb begin
    calcWl    = 1'b0;
    calcBlDrv = '0;
    calcBlVal = '0;
    auxWl     = 1'b0;
    auxBlDrv  = '0;
    auxBlVal  = '0;
    unique case (stb.phase)
      PH_INIT: begin
        calcWl    = 1'b1;
        auxWl     = 1'b1;
        calcBlDrv = '1;
        auxBlDrv  = '1;
      end
      PH_PROG: begin
        calcWl    = carryIn;
        auxWl     = carryIn;
        calcBlDrv = '1;
        calcBlVal = '1;
        auxBlDrv  = '1;
        auxBlVal  = '1;
      end
      PH_PREP: begin
        calcWl    = aBit;
        auxWl     = aBit;
        calcBlDrv = selHere | selAbove;
        calcBlVal = ({W{bBit}} & selHere) | ({W{~bBit}} & selAbove);
        auxBlDrv  = selHere | selAbove;
        auxBlVal  = {W{~bBit}} & (selHere | selAbove);
      end
      PH_FIN: begin
        auxWl     = 1'b1;
        auxBlDrv  = selHere;
        calcWl    = bBit;
        calcBlDrv = selHere;
        calcBlVal = {W{auxSense}} & selHere;
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/precalcAdderSeq.sv
module precalcAdderSeq
  import adderSeqPkg::*;
#(
  parameter int N = 8,
  localparam int W = N + 1,
  localparam int IDXW = $clog2(N + 1)
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         start,
  input  logic         sub,
  input  logic [N-1:0] aIn,
  input  logic [N-1:0] bIn,
  input  logic         cIn,
  input  logic         auxSense,
  output logic         busy,
  output logic         done,
  output logic         calcWl,
  output logic [W-1:0] calcBlDrv,
  output logic [W-1:0] calcBlVal,
  output logic         auxWl,
  output logic [W-1:0] auxBlDrv,
  output logic [W-1:0] auxBlVal
);

  ctrlStb_t        ctrlStb;
  logic [IDXW-1:0] stepIdx;

  addSeqCtrl #(.N(N), .IDXW(IDXW)) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .start   (start),
    .stb     (ctrlStb),
    .stepIdx (stepIdx),
    .busy    (busy),
    .done    (done)
  );

  addSeqData #(.N(N), .W(W), .IDXW(IDXW)) u_data (
    .clk       (clk),
    .rstN      (rstN),
    .stb       (ctrlStb),
    .stepIdx   (stepIdx),
    .sub       (sub),
    .aIn       (aIn),
    .bIn       (bIn),
    .cIn       (cIn),
    .auxSense  (auxSense),
    .calcWl    (calcWl),
    .calcBlDrv (calcBlDrv),
    .calcBlVal (calcBlVal),
    .auxWl     (auxWl),
    .auxBlDrv  (auxBlDrv),
    .auxBlVal  (auxBlVal)
  );

endmodule

// File: rtl/precalcAdderSeqChk.sv
module precalcAdderSeqChk
  import adderSeqPkg::*;
#(
  parameter int N = 8,
  localparam int W = N + 1,
  localparam int CW = $clog2(2 * N + 6) + 1
) (
  input logic         clk,
  input logic         rstN,
  input logic         busy,
  input logic         done,
  input phase_t       phase,
  input logic         auxSense,
  input logic         calcWl,
  input logic [W-1:0] calcBlDrv,
  input logic [W-1:0] calcBlVal,
  input logic         auxWl,
  input logic [W-1:0] auxBlDrv,
  input logic [W-1:0] auxBlVal
);

  localparam logic [CW-1:0] RUN_LEN = CW'(2 * (N + 1) + 2);

  logic [CW-1:0] busyCnt;

  always_ff @(posedge clk) begin
    if (!rstN || !busy) busyCnt <= '0;
    else                busyCnt <= busyCnt + 1'b1;
  end

  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (calcBlDrv == '0) && (auxBlDrv == '0) && !calcWl && !auxWl);

  // A restart while busy (R9) would also break this length
  assert_run_length_R2: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> (busyCnt == RUN_LEN));

  assert_done_at_end_R2: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> done);

  assert_done_single_R2: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  assert_clear_step_R3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> calcWl && auxWl && (&calcBlDrv) && (&auxBlDrv)
                    && (calcBlVal == '0) && (auxBlVal == '0));

  assert_prep_rows_R5: assert property (@(posedge clk) disable iff (!rstN)
    (phase == PH_PREP) |-> (calcBlDrv == auxBlDrv) && (calcWl == auxWl));

  assert_prep_shrink_R5: assert property (@(posedge clk) disable iff (!rstN)
    (phase == PH_PREP) && ($past(phase) == PH_PREP)
      |-> ($countones(auxBlDrv) + 1 == $countones($past(auxBlDrv))));

  assert_fin_single_R6: assert property (@(posedge clk) disable iff (!rstN)
    (phase == PH_FIN) |-> ($countones(calcBlDrv) == 1) && (calcBlDrv == auxBlDrv)
                          && auxWl && ((auxBlVal & auxBlDrv) == '0));

  assert_fin_forward_R6: assert property (@(posedge clk) disable iff (!rstN)
    (phase == PH_FIN) |-> ((calcBlVal & calcBlDrv) == (auxSense ? calcBlDrv : '0)));

endmodule

bind precalcAdderSeq precalcAdderSeqChk #(.N(N)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .busy      (busy),
  .done      (done),
  .phase     (ctrlStb.phase),
  .auxSense  (auxSense),
  .calcWl    (calcWl),
  .calcBlDrv (calcBlDrv),
  .calcBlVal (calcBlVal),
  .auxWl     (auxWl),
  .auxBlDrv  (auxBlDrv),
  .auxBlVal  (auxBlVal)
);

// File: tb/test_precalcAdderSeq.sv
module test_precalcAdderSeq;

  localparam int CLK_PERIOD = 10;
  localparam int N = 4;
  localparam int W = N + 1;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         start = 1'b0;
  logic         sub = 1'b0;
  logic [N-1:0] aIn = '0;
  logic [N-1:0] bIn = '0;
  logic         cIn = 1'b0;
  logic         auxSense;
  logic         busy, done, calcWl, auxWl;
  logic [W-1:0] calcBlDrv, calcBlVal, auxBlDrv, auxBlVal;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  precalcAdderSeq #(.N(N)) i_precalcAdderSeq (
    .clk(clk), .rstN(rstN), .start(start), .sub(sub), .aIn(aIn), .bIn(bIn),
    .cIn(cIn), .auxSense(auxSense), .busy(busy), .done(done),
    .calcWl(calcWl), .calcBlDrv(calcBlDrv), .calcBlVal(calcBlVal),
    .auxWl(auxWl), .auxBlDrv(auxBlDrv), .auxBlVal(auxBlVal)
  );

  // Behavioural model of both cell rows
  logic [W-1:0] calcCell = '0;
  logic [W-1:0] auxCell = '0;

  always @(posedge clk) begin
    for (int j = 0; j < W; j++) begin
      if (calcBlDrv[j])
        calcCell[j] <= calcCell[j] ? (calcWl | ~calcBlVal[j]) : (calcWl & ~calcBlVal[j]);
      if (auxBlDrv[j])
        auxCell[j] <= auxCell[j] ? (auxWl | ~auxBlVal[j]) : (auxWl & ~auxBlVal[j]);
    end
  end

  assign auxSense = auxWl & (|(auxBlDrv & ~auxBlVal & auxCell));

  task automatic check(input logic ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic expCmd(input int k, input logic [W-1:0] ae, input logic [W-1:0] be,
                        input logic ce, output logic [4*W+1:0] cmd, output string req);
    logic eWlC, eWlA;
    logic [W-1:0] eDC, eVC, eDA, eVA;
    logic [W:0] cy;
    cy[0] = ce;
    for (int i = 0; i < W; i++)
      cy[i+1] = (ae[i] & be[i]) | (ae[i] & cy[i]) | (be[i] & cy[i]);
    eWlC = 0; eWlA = 0; eDC = '0; eVC = '0; eDA = '0; eVA = '0;
    req = "R1";
    if (k == 0) begin
      req = "R3"; eWlC = 1; eWlA = 1; eDC = '1; eDA = '1;
    end else if (k == 1) begin
      req = "R4"; eWlC = ce; eWlA = ce; eDC = '1; eDA = '1; eVC = '1; eVA = '1;
    end else if (k >= 2 && k <= N + 2) begin
      int i = k - 2;
      req = "R5"; eWlC = ae[i]; eWlA = ae[i];
      for (int j = i; j < W; j++) begin
        eDC[j] = 1; eDA[j] = 1; eVA[j] = ~be[i];
        eVC[j] = (j == i) ? be[i] : ~be[i];
      end
    end else if (k >= N + 3 && k <= 2 * N + 3) begin
      int i = k - N - 3;
      req = "R6"; eWlA = 1; eDA[i] = 1; eWlC = be[i]; eDC[i] = 1; eVC[i] = cy[i+1];
    end
    cmd = {eWlC, eWlA, eDC, eVC, eDA, eVA};
  endtask

  task automatic checkIdle(input string tag);
    check(!busy && !done && !calcWl && !auxWl && calcBlDrv == '0 && auxBlDrv == '0,
          tag, {busy, done, calcWl, auxWl, calcBlDrv, auxBlDrv}, '0);
  endtask

  // One operation; poke = 1 fires a second start with other operands mid-run
  task automatic runOp(input logic [N-1:0] a, input logic [N-1:0] b, input logic c0,
                       input logic sb, input logic poke);
    logic [W-1:0] ae, be, expSum;
    logic ce;
    logic [4*W+1:0] expC, actC;
    string req;
    ae = {a[N-1], a};
    be = sb ? ~{b[N-1], b} : {b[N-1], b};
    ce = sb | c0;
    expSum = ae + be + W'(ce);
    @(negedge clk);
    aIn = a; bIn = b; cIn = c0; sub = sb; start = 1'b1;
    for (int k = 0; k <= 2 * N + 3; k++) begin
      @(negedge clk);
      start = 1'b0;
      if (poke && k == 3) begin
        start = 1'b1; aIn = ~a; bIn = ~b; cIn = ~c0; sub = ~sb;
      end
      expCmd(k, ae, be, ce, expC, req);
      actC = {calcWl, auxWl, calcBlDrv, calcBlVal, auxBlDrv, auxBlVal};
      check(busy && !done && actC == expC, poke ? "R9" : req, {busy, done, actC}, {2'b10, expC});
    end
    @(negedge clk);
    start = 1'b0;
    check(done && !busy, "R2", {done, busy}, 2'b10);
    check(calcCell == expSum, sb ? "R8" : "R7", calcCell, expSum);
    @(negedge clk);
    checkIdle("R1");
    check(calcCell == expSum, "R9", calcCell, expSum);
  endtask

  task automatic testReset();
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    checkIdle("R1");
    rstN = 1'b1;
    @(negedge clk);
    checkIdle("R1");
  endtask

  task automatic testCorners();
    runOp(4'h7, 4'h7, 1'b1, 1'b0, 1'b0);   // R7: 15 needs the extra bit
    runOp(4'h8, 4'h8, 1'b0, 1'b0, 1'b0);   // R7: -16
    runOp(4'h8, 4'h7, 1'b0, 1'b1, 1'b0);   // R8: -8 - 7 = -15
    runOp(4'h3, 4'h5, 1'b0, 1'b1, 1'b0);   // R8 with c0 ignored
  endtask

  task automatic testStartWhileBusy();
    runOp(4'h5, 4'h6, 1'b0, 1'b0, 1'b1);   // R9
    runOp(4'hC, 4'h2, 1'b1, 1'b1, 1'b1);   // R9
  endtask

  task automatic testExhaustive();
    for (int m = 0; m < 3; m++)
      for (int a = 0; a < (1 << N); a++)
        for (int b = 0; b < (1 << N); b++)
          runOp(N'(a), N'(b), (m == 1), (m == 2), 1'b0);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    checks++;
    $display("FAIL watchdog R2 actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    testReset();
    testCorners();
    testStartWhileBusy();
    testExhaustive();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule